// File: doc/BRIEF.md
# Shared Byte-Store Arbiter for a Serial Queue Engine

This block owns an 80-byte storage array that two masters share: a processor bus port and the port of a serial queue engine. The array is cut into three regions used by the engine: 32 bytes of receive data at 0x00, 32 bytes of transmit data at 0x20 and 16 bytes of command entries at 0x40. The processor reads and writes bytes, 16-bit words or 32-bit long-words with a request/ready handshake. The engine reads or writes one byte or one word per granted cycle.

While the engine is switched on, the arbiter holds each processor access back by one to four wait cycles. The engine takes the array whenever it asks and the processor has waited fewer than four cycles. An aligned word from the processor is done in one indivisible array cycle. A long-word or an odd-address word is done as two separate halves, and the engine may be served in the gap between them. With the engine switched off, processor accesses see no arbitration delay.

The processor holds `cpu_req` and the access fields steady until it samples `cpu_ready` high, then releases the request. The engine does the same with `eng_req` and `eng_ack`.

Top module: `shram_arbiter`

## Requirements
- R1: The array holds 80 bytes (receive 0x00-0x1F, transmit 0x20-0x3F, command 0x40-0x4F); any byte lane whose address is 0x50 or above reads as zero and is not written, from either port.
- R2: Data is big-endian and right-justified: `cpu_size` 0 is a byte in `cpu_wdata/cpu_rdata[7:0]`, 1 is a word in [15:0], 2 (and 3) is a long-word in [31:0]; the lowest address always holds the most significant byte.
- R3: With `eng_enable` low, a byte or aligned-word access raises `cpu_ready` in the first cycle of its request, a split access in the second cycle, and `eng_ack` stays low.
- R4: With `eng_enable` high, every processor half waits at least one cycle; with the engine idle a byte or aligned word is ready in cycle 2 and a split access in cycle 4.
- R5: When both ports want the array, the engine is granted while the processor half has waited fewer than 4 cycles; after 4 wait cycles the processor is granted even if the engine keeps requesting.
- R6: An aligned processor word is written in one array cycle, so an engine word read of that address returns either the complete old or the complete new value, never a mix.
- R7: A long-word is done as two word halves (address, address+2); an odd-address word as two byte halves (address, address+1); the engine may be granted between the halves and then sees the first half already written.
- R8: `cpu_ready` is high for exactly the cycle of the final half's grant; `cpu_rdata` carries the read value in that cycle and is zero in every other cycle.
- R9: The engine port acts only while `eng_enable` is high: `eng_ack` is raised in the grant cycle with `eng_rdata` holding the word (`eng_word`=1) or the byte in [7:0]; writes use `eng_wdata` the same way.
- R10: After reset every byte reads zero, `cpu_ready` and `eng_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_enable | input | 1 | Engine switched on; enables arbitration and wait states |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_size | input | 2 | 0 byte, 1 word, 2 or 3 long-word |
| cpu_addr | input | 7 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data, right-justified |
| cpu_rdata | output | 32 | Processor read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| eng_req | input | 1 | Engine request, held until ack |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_word | input | 1 | Engine word (1) or byte (0) access |
| eng_addr | input | 7 | Engine byte address |
| eng_wdata | input | 16 | Engine write data, right-justified |
| eng_rdata | output | 16 | Engine read data, valid with ack |
| eng_ack | output | 1 | Engine grant/completion in the same cycle |

## Verification
The two functions that meet in one cycle are the engine's claim on the array and the processor's wait-count ceiling: with the engine requesting every cycle, the processor request is raised on the same edge and the bench samples both handshakes in each following cycle, expecting four engine grants and then a processor completion with the engine refused. A second meeting point is a split long-word whose gap is filled by an engine read; it is provoked by raising the engine request in the cycle after the first half and judged by the engine reading the new first-half byte beside the still-old neighbour. Atomicity of an aligned word is judged by the engine reading the same word every cycle across the processor write and never seeing a mixed value.

// File: rtl/shram_pkg.sv
package shram_pkg;

  // Processor access sizes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SZ_RSVD = 2'd3;

  // One array cycle: one or two bytes starting at addr
  typedef struct packed {
    logic [7:0]  addr;
    logic        two;
    logic [15:0] wdata;
  } half_t;

  // True when the access needs two array cycles
  function automatic logic split_access(input logic [1:0] sz, input logic a0);
    return (sz == SZ_LONG) || (sz == SZ_RSVD) || ((sz == SZ_WORD) && a0);
  endfunction

  // Address, lane count and data for half h of a processor access
  function automatic half_t plan_half(input logic [1:0] sz, input logic [6:0] a,
                                      input logic h, input logic [31:0] wd);
    half_t p;
    logic [7:0] base;
    base    = {1'b0, a};
    p.addr  = base;
    p.two   = 1'b0;
    p.wdata = {8'h00, wd[7:0]};
    case (sz)
      SZ_BYTE: begin
        p.wdata = {8'h00, wd[7:0]};
      end
      SZ_WORD: begin
        if (!a[0]) begin
          p.two   = 1'b1;
          p.wdata = wd[15:0];
        end else if (!h) begin
          p.wdata = {8'h00, wd[15:8]};
        end else begin
          p.addr  = base + 8'd1;
          p.wdata = {8'h00, wd[7:0]};
        end
      end
      default: begin
        p.two = 1'b1;
        if (!h) begin
          p.wdata = wd[31:16];
        end else begin
          p.addr  = base + 8'd2;
          p.wdata = wd[15:0];
        end
      end
    endcase
    return p;
  endfunction

  // Final processor read value from the held first half and the last read
  function automatic logic [31:0] assemble(input logic [1:0] sz, input logic a0,
                                           input logic [15:0] hold, input logic [15:0] rd);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {24'h0, rd[7:0]};
      SZ_WORD: r = a0 ? {16'h0, hold[7:0], rd[7:0]} : {16'h0, rd};
      default: r = {hold, rd};
    endcase
    return r;
  endfunction

  // Byte lane exists in the array
  function automatic logic byte_present(input logic [7:0] a, input int unsigned depth);
    return ({24'h0, a} < depth);
  endfunction

endpackage

// File: rtl/shram_store.sv
module shram_store
  import shram_pkg::*;
#(
  parameter int unsigned DEPTH = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        two,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned LANES = 2;

  logic [7:0] mem [DEPTH];

  logic [7:0] lane_addr [LANES];
  logic       lane_on   [LANES];
  logic       lane_ok   [LANES];
  logic [7:0] lane_wd   [LANES];
  logic [7:0] lane_rd   [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = addr + 8'(k);
    assign lane_ok[k]   = byte_present(lane_addr[k], DEPTH);
    if (k == 0) begin : g_first
      assign lane_on[k] = 1'b1;
      assign lane_wd[k] = two ? wdata[15:8] : wdata[7:0];
    end else begin : g_second
      assign lane_on[k] = two;
      assign lane_wd[k] = wdata[7:0];
    end
    assign lane_rd[k] = lane_ok[k] ? mem[lane_addr[k][IDX_W-1:0]] : 8'h00;
  end

  assign rdata = two ? {lane_rd[0], lane_rd[1]} : {8'h00, lane_rd[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_on[k] && lane_ok[k]) mem[lane_addr[k][IDX_W-1:0]] <= lane_wd[k];
      end
    end
  end

endmodule

// File: rtl/shram_arb.sv
module shram_arb #(
  parameter int unsigned MAX_WAIT = 4,
  localparam int unsigned WCNT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_enable,
  input  logic              eng_req,
  input  logic              cpu_req,
  output logic              cpu_gnt,
  output logic              eng_gnt,
  output logic [WCNT_W-1:0] wcnt
);
  localparam logic [WCNT_W-1:0] WMAX = WCNT_W'(MAX_WAIT);

  logic eng_want;
  logic cpu_waited;
  logic cpu_forced;

  assign eng_want   = eng_req && eng_enable;
  assign cpu_waited = (wcnt != '0);
  assign cpu_forced = (wcnt == WMAX);

  always_comb begin
    if (!eng_enable) cpu_gnt = cpu_req;
    else             cpu_gnt = cpu_req && cpu_waited && (!eng_want || cpu_forced);
    eng_gnt = eng_want && !cpu_gnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  wcnt <= '0;
    else if (!cpu_req || cpu_gnt) wcnt <= '0;
    else if (!cpu_forced)        wcnt <= wcnt + 1'b1;
  end

endmodule

// File: rtl/shram_cpu_seq.sv
module shram_cpu_seq
  import shram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic [1:0]  cpu_size,
  input  logic [6:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic        cpu_gnt,
  input  logic [15:0] rd,
  output half_t       plan,
  output logic        half_q,
  output logic        cpu_last,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata
);
  logic        split;
  logic [15:0] hold_q;

  assign split     = split_access(cpu_size, cpu_addr[0]);
  assign cpu_last  = !split || half_q;
  assign plan      = plan_half(cpu_size, cpu_addr, half_q, cpu_wdata);
  assign cpu_ready = cpu_gnt && cpu_last;
  assign cpu_rdata = cpu_ready ? assemble(cpu_size, cpu_addr[0], hold_q, rd) : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hold_q <= 16'h0;
    end else if (!cpu_req) begin
      half_q <= 1'b0;
    end else if (cpu_gnt) begin
      half_q <= !cpu_last;
      if (!cpu_last) hold_q <= rd;
    end
  end

endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
  import shram_pkg::*;
#(
  parameter int unsigned RX_BYTES  = 32,
  parameter int unsigned TX_BYTES  = 32,
  parameter int unsigned CMD_BYTES = 16,
  parameter int unsigned MAX_WAIT  = 4,
  localparam int unsigned DEPTH    = RX_BYTES + TX_BYTES + CMD_BYTES,
  localparam int unsigned WCNT_W   = $clog2(MAX_WAIT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eng_enable,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [6:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  input  logic        eng_req,
  input  logic        eng_we,
  input  logic        eng_word,
  input  logic [6:0]  eng_addr,
  input  logic [15:0] eng_wdata,
  output logic [15:0] eng_rdata,
  output logic        eng_ack
);
  // Named internal events
  logic              cpu_gnt;
  logic              eng_gnt;
  logic [WCNT_W-1:0] wcnt;
  logic              half_q;
  logic              cpu_last;
  half_t             cpu_plan;
  half_t             eng_plan;
  half_t             acc;
  logic              acc_we;
  logic [15:0]       rd;

  shram_arb #(.MAX_WAIT(MAX_WAIT)) i_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_enable (eng_enable),
    .eng_req    (eng_req),
    .cpu_req    (cpu_req),
    .cpu_gnt    (cpu_gnt),
    .eng_gnt    (eng_gnt),
    .wcnt       (wcnt)
  );

  shram_cpu_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_size  (cpu_size),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_gnt   (cpu_gnt),
    .rd        (rd),
    .plan      (cpu_plan),
    .half_q    (half_q),
    .cpu_last  (cpu_last),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata)
  );

  assign eng_plan = '{addr: {1'b0, eng_addr}, two: eng_word, wdata: eng_wdata};
  assign acc      = cpu_gnt ? cpu_plan : eng_plan;
  assign acc_we   = (cpu_gnt && cpu_we) || (eng_gnt && eng_we);

  shram_store #(.DEPTH(DEPTH)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (acc.addr),
    .two   (acc.two),
    .we    (acc_we),
    .wdata (acc.wdata),
    .rdata (rd)
  );

  assign eng_ack   = eng_gnt;
  assign eng_rdata = eng_gnt ? rd : 16'h0;

endmodule

// File: rtl/shram_arbiter_chk.sv
module shram_arbiter_chk #(
  parameter int unsigned MAX_WAIT = 4,
  localparam int unsigned WCNT_W  = $clog2(MAX_WAIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_enable,
  input logic              eng_req,
  input logic              cpu_req,
  input logic              cpu_gnt,
  input logic              eng_gnt,
  input logic [WCNT_W-1:0] wcnt,
  input logic              cpu_ready,
  input logic [31:0]       cpu_rdata,
  input logic              eng_ack
);
  localparam logic [WCNT_W-1:0] WMAX = WCNT_W'(MAX_WAIT);

  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && eng_gnt));

  a_r3_no_delay_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_enable && cpu_req) |-> (cpu_gnt && !eng_ack));

  a_r4_first_cycle_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_enable && cpu_req && wcnt == '0) |-> !cpu_gnt);

  a_r4_wait_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_enable && cpu_req && !cpu_gnt && wcnt != WMAX) |=>
      (!cpu_req || !eng_enable || wcnt == $past(wcnt) + 1'b1));

  a_r5_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_enable && eng_req && cpu_req && wcnt != WMAX) |-> (eng_gnt && !cpu_gnt));

  a_r5_wait_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_enable && cpu_req && wcnt == WMAX) |-> cpu_gnt);

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WMAX);

  a_r8_ready_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_gnt);

  a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (cpu_rdata == 32'h0));

  a_r9_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack |-> (eng_enable && eng_req));

endmodule

bind shram_arbiter shram_arbiter_chk #(.MAX_WAIT(MAX_WAIT)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_enable (eng_enable),
  .eng_req    (eng_req),
  .cpu_req    (cpu_req),
  .cpu_gnt    (cpu_gnt),
  .eng_gnt    (eng_gnt),
  .wcnt       (wcnt),
  .cpu_ready  (cpu_ready),
  .cpu_rdata  (cpu_rdata),
  .eng_ack    (eng_ack)
);

// File: tb/test_shram_arbiter.sv
module test_shram_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_enable = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [6:0]  cpu_addr = 7'h0;
  logic [31:0] cpu_wdata = 32'h0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        eng_req = 1'b0;
  logic        eng_we = 1'b0;
  logic        eng_word = 1'b0;
  logic [6:0]  eng_addr = 7'h0;
  logic [15:0] eng_wdata = 16'h0;
  logic [15:0] eng_rdata;
  logic        eng_ack;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] ref_mem [80];

  shram_arbiter i_shram_arbiter (
    .clk(clk), .rst_n(rst_n), .eng_enable(eng_enable),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .eng_req(eng_req), .eng_we(eng_we), .eng_word(eng_word), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_ack(eng_ack)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference store: bytes at 80 and above do not exist
  function automatic logic [7:0] rb(input int a);
    return (a < 80) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic put(input int a, input logic [7:0] v);
    if (a < 80) ref_mem[a] = v;
  endtask

  function automatic logic [31:0] ref_read(input logic [1:0] sz, input int a);
    if (sz == 2'd0) return {24'h0, rb(a)};
    if (sz == 2'd1) return {16'h0, rb(a), rb(a + 1)};
    return {rb(a), rb(a + 1), rb(a + 2), rb(a + 3)};
  endfunction

  task automatic ref_write(input logic [1:0] sz, input int a, input logic [31:0] wd);
    if (sz == 2'd0) put(a, wd[7:0]);
    else if (sz == 2'd1) begin put(a, wd[15:8]); put(a + 1, wd[7:0]); end
    else begin
      put(a, wd[31:24]); put(a + 1, wd[23:16]); put(a + 2, wd[15:8]); put(a + 3, wd[7:0]);
    end
  endtask

  // One processor access; returns read value and the cycle of ready (1 = first)
  task automatic cpu_op(input logic [1:0] sz, input logic [6:0] a, input logic we,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; rd = 32'hx;
    for (int i = 0; i < 40; i++) begin
      #1;
      cyc++;
      if (cpu_ready) begin rd = cpu_rdata; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) ref_write(sz, a, wd);
  endtask

  task automatic eng_op(input logic we, input logic word, input logic [6:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output int cyc);
    @(negedge clk);
    eng_req = 1'b1; eng_we = we; eng_word = word; eng_addr = a; eng_wdata = wd;
    cyc = 0; rd = 16'hx;
    for (int i = 0; i < 40; i++) begin
      #1;
      cyc++;
      if (eng_ack) begin rd = eng_rdata; break; end
      @(negedge clk);
    end
    @(negedge clk);
    eng_req = 1'b0; eng_we = 1'b0;
    if (we) begin
      if (word) begin put(a, wd[15:8]); put(a + 1, wd[7:0]); end
      else put(a, wd[7:0]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] r; int c;
    chk("R10 ready low after reset", {31'h0, cpu_ready}, 32'h0);
    chk("R10 ack low after reset", {31'h0, eng_ack}, 32'h0);
    cpu_op(2'd2, 7'h00, 1'b0, 32'h0, r, c);
    chk("R10 array zero after reset", r, 32'h0);
    cpu_op(2'd2, 7'h4C, 1'b0, 32'h0, r, c);
    chk("R10 command region zero", r, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] r; int c;
    eng_enable = 1'b0;
    cpu_op(2'd0, 7'h05, 1'b1, 32'h0000_00A5, r, c);
    chk("R3 byte write cycles", c, 1);
    cpu_op(2'd1, 7'h20, 1'b1, 32'h0000_1234, r, c);
    chk("R3 word write cycles", c, 1);
    cpu_op(2'd2, 7'h40, 1'b1, 32'hDEAD_BEEF, r, c);
    chk("R3 long write cycles", c, 2);
    cpu_op(2'd0, 7'h05, 1'b0, 32'h0, r, c);
    chk("R3 byte read value", r, ref_read(2'd0, 5));
    chk("R3 byte read cycles", c, 1);
    @(negedge clk);
    eng_req = 1'b1; eng_word = 1'b1; eng_we = 1'b1; eng_addr = 7'h05; eng_wdata = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 no ack while engine off", {31'h0, eng_ack}, 32'h0);
      @(negedge clk);
    end
    eng_req = 1'b0; eng_we = 1'b0;
    cpu_op(2'd1, 7'h04, 1'b0, 32'h0, r, c);
    chk("R9 engine write ignored while off", r, ref_read(2'd1, 4));
  endtask

  task automatic t_endian;
    logic [31:0] r; int c;
    cpu_op(2'd0, 7'h40, 1'b0, 32'h0, r, c);
    chk("R2 lowest address is MSB", r, 32'h0000_00DE);
    cpu_op(2'd0, 7'h43, 1'b0, 32'h0, r, c);
    chk("R2 highest address is LSB", r, 32'h0000_00EF);
    cpu_op(2'd1, 7'h42, 1'b0, 32'h0, r, c);
    chk("R2 word read", r, 32'h0000_BEEF);
    cpu_op(2'd1, 7'h41, 1'b0, 32'h0, r, c);
    chk("R7 odd word read value", r, 32'h0000_ADBE);
    chk("R7 odd word split while off", c, 2);
  endtask

  task automatic t_enabled_idle;
    logic [31:0] r; int c;
    eng_enable = 1'b1;
    cpu_op(2'd0, 7'h05, 1'b0, 32'h0, r, c);
    chk("R4 byte one wait", c, 2);
    cpu_op(2'd1, 7'h20, 1'b0, 32'h0, r, c);
    chk("R4 word one wait", c, 2);
    chk("R4 word value", r, 32'h0000_1234);
    cpu_op(2'd2, 7'h40, 1'b0, 32'h0, r, c);
    chk("R4 long two halves each waiting", c, 4);
    chk("R4 long value", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_engine_port;
    logic [31:0] r; logic [15:0] e; int c;
    eng_enable = 1'b1;
    eng_op(1'b1, 1'b1, 7'h24, 16'hCAFE, e, c);
    chk("R9 engine ack first cycle", c, 1);
    cpu_op(2'd0, 7'h24, 1'b0, 32'h0, r, c);
    chk("R9 engine word high byte at low address", r, 32'h0000_00CA);
    eng_op(1'b0, 1'b0, 7'h25, 16'h0, e, c);
    chk("R9 engine byte read", {16'h0, e}, 32'h0000_00FE);
    eng_op(1'b0, 1'b1, 7'h40, 16'h0, e, c);
    chk("R9 engine word read", {16'h0, e}, 32'h0000_DEAD);
  endtask

  task automatic t_saturate;
    eng_enable = 1'b1;
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b0; eng_word = 1'b1; eng_addr = 7'h40;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd0; cpu_addr = 7'h05;
    for (int i = 1; i <= 5; i++) begin
      #1;
      if (i < 5) begin
        chk("R5 engine wins while waiting", {31'h0, eng_ack}, 32'h1);
        chk("R5 processor held", {31'h0, cpu_ready}, 32'h0);
        chk("R8 rdata zero while waiting", cpu_rdata, 32'h0);
      end else begin
        chk("R5 processor granted after four waits", {31'h0, cpu_ready}, 32'h1);
        chk("R5 engine refused at ceiling", {31'h0, eng_ack}, 32'h0);
        chk("R8 rdata at ready", cpu_rdata, ref_read(2'd0, 5));
      end
      @(negedge clk);
    end
    cpu_req = 1'b0; eng_req = 1'b0;
    #1;
    chk("R8 ready is a single pulse", {31'h0, cpu_ready}, 32'h0);
  endtask

  task automatic t_odd_word;
    logic [31:0] r; int c;
    eng_enable = 1'b1;
    cpu_op(2'd1, 7'h31, 1'b1, 32'h0000_ABCD, r, c);
    chk("R7 odd word write two halves", c, 4);
    cpu_op(2'd0, 7'h31, 1'b0, 32'h0, r, c);
    chk("R7 first byte half", r, 32'h0000_00AB);
    cpu_op(2'd0, 7'h32, 1'b0, 32'h0, r, c);
    chk("R7 second byte half", r, 32'h0000_00CD);
    cpu_op(2'd1, 7'h31, 1'b0, 32'h0, r, c);
    chk("R7 odd word read back", r, 32'h0000_ABCD);
  endtask

  task automatic t_interleave;
    logic [31:0] r; logic [15:0] exp_e; int c;
    eng_enable = 1'b1;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd2; cpu_addr = 7'h20; cpu_wdata = 32'h1122_3344;
    #1; chk("R7 long cycle 1 waits", {31'h0, cpu_ready}, 32'h0);
    @(negedge clk);
    #1; chk("R7 long cycle 2 first half only", {31'h0, cpu_ready}, 32'h0);
    @(negedge clk);
    exp_e = {8'h22, rb(8'h22)};
    eng_req = 1'b1; eng_we = 1'b0; eng_word = 1'b1; eng_addr = 7'h21;
    #1;
    chk("R7 engine served between halves", {31'h0, eng_ack}, 32'h1);
    chk("R7 engine sees first half only", {16'h0, eng_rdata}, {16'h0, exp_e});
    chk("R7 processor not ready in gap", {31'h0, cpu_ready}, 32'h0);
    @(negedge clk);
    eng_req = 1'b0;
    #1; chk("R7 second half completes", {31'h0, cpu_ready}, 32'h1);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    ref_write(2'd2, 8'h20, 32'h1122_3344);
    cpu_op(2'd2, 7'h20, 1'b0, 32'h0, r, c);
    chk("R7 long read back", r, 32'h1122_3344);
  endtask

  task automatic t_atomic;
    logic [31:0] r; int c;
    eng_enable = 1'b1;
    @(negedge clk);
    eng_req = 1'b1; eng_we = 1'b0; eng_word = 1'b1; eng_addr = 7'h28;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd1; cpu_addr = 7'h28; cpu_wdata = 32'h0000_9876;
    for (int i = 1; i <= 5; i++) begin
      #1;
      if (i < 5) chk("R6 engine sees whole old word", {16'h0, eng_rdata}, 32'h0);
      else       chk("R6 word written in one grant", {31'h0, cpu_ready}, 32'h1);
      @(negedge clk);
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
    chk("R6 engine sees whole new word", {15'h0, eng_ack, eng_rdata}, 32'h0001_9876);
    @(negedge clk);
    eng_req = 1'b0;
    ref_write(2'd1, 8'h28, 32'h0000_9876);
    cpu_op(2'd1, 7'h28, 1'b0, 32'h0, r, c);
    chk("R6 word read back", r, 32'h0000_9876);
  endtask

  task automatic t_range;
    logic [31:0] r; logic [15:0] e; int c;
    eng_enable = 1'b0;
    cpu_op(2'd2, 7'h4E, 1'b1, 32'hAABB_CCDD, r, c);
    cpu_op(2'd2, 7'h4E, 1'b0, 32'h0, r, c);
    chk("R1 long across end reads zero beyond", r, 32'hAABB_0000);
    cpu_op(2'd0, 7'h7F, 1'b1, 32'h0000_0055, r, c);
    cpu_op(2'd0, 7'h7F, 1'b0, 32'h0, r, c);
    chk("R1 write beyond end ignored", r, 32'h0);
    cpu_op(2'd1, 7'h1F, 1'b1, 32'h0000_7788, r, c);
    cpu_op(2'd2, 7'h1C, 1'b0, 32'h0, r, c);
    chk("R1 receive/transmit boundary", r, ref_read(2'd2, 8'h1C));
    eng_enable = 1'b1;
    eng_op(1'b1, 1'b1, 7'h4F, 16'h1122, e, c);
    eng_op(1'b0, 1'b1, 7'h4F, 16'h0, e, c);
    chk("R1 engine word at end", {16'h0, e}, 32'h0000_1100);
    eng_op(1'b0, 1'b0, 7'h50, 16'h0, e, c);
    chk("R1 engine beyond end zero", {16'h0, e}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R-watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 80; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_disabled();
    t_endian();
    t_enabled_idle();
    t_engine_port();
    t_saturate();
    t_odd_word();
    t_interleave();
    t_atomic();
    t_range();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule